// File: doc/BRIEF.md
# Halfband Decimate-by-Two Filter

This block is an 11-tap (10th-order) halfband low-pass FIR. It lowers a stream of signed samples to half their rate. Its 6 dB point sits at one quarter of the input rate. Every other tap is zero, apart from the centre tap of exactly one half. The filter runs in polyphase form. Even-indexed samples enter a delay line whose symmetric taps are folded and pre-added. Odd-indexed samples enter a pure delay line that feeds the centre tap. One result is formed per pair of inputs, and neither branch does any work at the input rate.

The block has no multipliers. Each constant is a canonical signed digit value, evaluated in nested form with shifts and adds. The internal word is 24 bits for a 16-bit signal, which leaves enough fractional bits that every partial product stays exact. The sum is rounded half-up to the output width and saturates on overflow. It is meant as the first, short halfband stage after a comb decimator. Inputs arrive with a valid strobe. One output strobe follows every second accepted input.

The taps, in units of 1/128, are 1, 0, -7, 0, 38, 64, 38, 0, -7, 0, 1. Tap j multiplies the input that is j accepted samples older than the newest one.

Top module: `halfband_dec2`

## Requirements
- R1: While rst_n is low, out_valid and out_data are 0 and both delay lines are cleared. After release, the next accepted sample has index 0. A reset in the middle of a stream restarts the indexing at 0.
- R2: An output is produced for each accepted sample with an even index (0, 2, 4, ...). out_valid is high for exactly the one cycle after the edge that accepted that sample, and out_data holds its value until the next pulse.
- R3: A cycle with in_valid low has no effect. The delay lines, the sample index and the outputs do not change, out_valid stays low and in_data is ignored. Results do not depend on gaps in the stream.
- R4: For even index n, let S = x[n] + x[n-10] - 7(x[n-2] + x[n-8]) + 38(x[n-4] + x[n-6]) + 64 x[n-5], with samples before index 0 taken as 0. The output is then computed from S as set out in R6 and R7.
- R5: Odd-indexed samples reach the output only through the centre tap. An odd sample x at index m contributes x/2 to the output emitted at index m+5, and to no other output.
- R6: The output is floor((S + 64) / 128), so a result of exactly half an LSB rounds toward positive infinity.
- R7: When the rounded value lies outside the signed OW-bit range, out_data saturates to the largest positive or most negative code.
- R8: A constant input settles to the same constant at the output (DC gain of exactly one).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_data carries a new sample this cycle |
| in_data | input | IW | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for a new output |
| out_data | output | OW | Signed filtered, decimated sample |

## Verification
Assertions check the output timing on every cycle. A strobe must come from an even-phase accepted input. Two strobes never fall on adjacent cycles. An idle input never yields a strobe. The output word never changes between strobes. The arithmetic cannot be checked by a property: the tap values, the exact half weight of the odd branch, half-up rounding, saturation at both rails, unity DC gain and the restart of the sample index after a mid-stream reset are shown only by the bench scenarios. Each of those scenarios is compared against an integer convolution model.

// File: rtl/halfband_dec2.sv
module halfband_dec2 #(
  parameter int IW    = 16,
  parameter int GUARD = 8,
  parameter int OW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] in_data,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);
  localparam int FRAC = GUARD - 1;
  localparam int AW   = IW + GUARD;
  localparam int NEV  = 5;
  localparam int NOD  = 3;
  localparam logic signed [AW-1:0] HALF = {{(AW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic [OW-1:0] SMAX = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] SMIN = {1'b1, {(OW-1){1'b0}}};

  function automatic logic signed [AW-1:0] ext(input logic [IW-1:0] x);
    return {{(GUARD-FRAC){x[IW-1]}}, x, {FRAC{1'b0}}};
  endfunction

  logic [IW-1:0] ev [NEV];
  logic [IW-1:0] od [NOD];
  logic          ph;
  logic          take_even;

  assign take_even = in_valid && !ph;

  logic signed [AW-1:0] p_out, p_mid, p_in;
  logic signed [AW-1:0] v, w, t_a, t_b, t_c, t_h, acc, rnd, q;
  logic                 ovf_pos, ovf_neg;
  logic [OW-1:0]        y;

  assign p_out = ext(in_data) + ext(ev[4]);
  assign p_mid = ext(ev[0]) + ext(ev[3]);
  assign p_in  = ext(ev[1]) + ext(ev[2]);

  assign t_a = p_out >>> 7;
  assign v   = p_mid >>> 4;
  assign t_b = (v >>> 3) - v;
  assign w   = p_in >>> 2;
  assign t_c = w + ((w - (w >>> 2)) >>> 2);
  assign t_h = ext(od[NOD-1]) >>> 1;

  assign acc = t_a + t_b + t_c + t_h;
  assign rnd = acc + HALF;
  assign q   = rnd >>> FRAC;

  assign ovf_pos = !q[AW-1] && (|q[AW-2:OW-1]);
  assign ovf_neg =  q[AW-1] && !(&q[AW-2:OW-1]);
  assign y = ovf_pos ? SMAX : ovf_neg ? SMIN : q[OW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int i = 0; i < NEV; i++) ev[i] <= '0;
      for (int i = 0; i < NOD; i++) od[i] <= '0;
    end else begin
      out_valid <= take_even;
      if (in_valid) begin
        ph <= !ph;
        if (!ph) begin
          ev[0] <= in_data;
          for (int i = 1; i < NEV; i++) ev[i] <= ev[i-1];
          out_data <= y;
        end else begin
          od[0] <= in_data;
          for (int i = 1; i < NOD; i++) od[i] <= od[i-1];
        end
      end
    end
  end

  // R2
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && !ph));

  // R2
  pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

// File: tb/sim_halfband_dec2.sv
module sim_halfband_dec2;
  localparam int IW = 16;
  localparam int OW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [IW-1:0] in_data = '0;
  logic          out_valid;
  logic [OW-1:0] out_data;

  always #2 clk = ~clk;

  halfband_dec2 #(.IW(IW), .GUARD(8), .OW(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  int hist[$];
  bit pend_v = 1'b0;
  int pend_d = 0;
  int coef[11] = '{1, 0, -7, 0, 38, 64, 38, 0, -7, 0, 1};

  function automatic int model_out();
    int n = hist.size() - 1;
    longint s = 0;
    longint r;
    for (int j = 0; j < 11; j++)
      if (n - j >= 0) s += longint'(coef[j]) * longint'(hist[n-j]);
    r = (s + 64) >>> 7;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (out_valid !== pend_v) begin
      errors++;
      $display("FAIL %s out_valid got %0b expected %0b", tag, out_valid, pend_v);
    end
    if (pend_v) begin
      checks++;
      if (int'($signed(out_data)) != pend_d) begin
        errors++;
        $display("FAIL %s out_data got %0d expected %0d", tag, $signed(out_data), pend_d);
      end
    end
  endtask

  task automatic step(input bit v, input int d, input string tag);
    in_valid = v;
    in_data  = d[IW-1:0];
    pend_v   = 1'b0;
    if (v) begin
      hist.push_back(int'($signed(in_data)));
      if ((hist.size() - 1) % 2 == 0) begin
        pend_v = 1'b1;
        pend_d = model_out();
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    hist.delete();
    pend_v = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs got %0b/%0d expected 0/0", out_valid, out_data);
    end
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired got hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int satv[11];
    do_reset();

    // R4: impulse at even index, taps read back
    step(1, 1024, "R4");
    for (int i = 0; i < 14; i++) step(1, 0, "R4");

    // R5: impulse at odd index reaches only the centre tap
    do_reset();
    step(1, 0, "R5");
    step(1, 2000, "R5");
    for (int i = 0; i < 14; i++) step(1, 0, "R5");

    // R6: half-LSB rounding
    do_reset();
    step(1, 64, "R6");
    do_reset();
    step(1, -64, "R6");
    do_reset();
    step(1, -65, "R6");
    do_reset();
    step(1, 0, "R6");
    step(1, 1, "R6");
    for (int i = 0; i < 6; i++) step(1, 0, "R6");
    do_reset();
    step(1, 0, "R6");
    step(1, -1, "R6");
    for (int i = 0; i < 6; i++) step(1, 0, "R6");

    // R7: saturation at both rails
    satv = '{32767, 0, -32768, 0, 32767, 32767, 32767, 0, -32768, 0, 32767};
    do_reset();
    for (int i = 0; i < 11; i++) step(1, satv[i], "R7");
    do_reset();
    for (int i = 0; i < 11; i++) step(1, -satv[i], "R7");

    // R8: DC gain of one
    do_reset();
    for (int i = 0; i < 24; i++) step(1, 1000, "R8");
    for (int i = 0; i < 24; i++) step(1, -20000, "R8");

    // R3: idle cycles with junk data leave the result unchanged
    do_reset();
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 2) == 0) step(0, int'($urandom), "R3");
      else step(1, int'($urandom_range(0, 65535)) - 32768, "R3");
    end

    // R2/R4: continuous random stream
    for (int i = 0; i < 300; i++) step(1, int'($urandom_range(0, 65535)) - 32768, "R2");

    // R1: mid-stream reset restarts the index
    step(1, 5000, "R1");
    do_reset();
    step(1, 7000, "R1");
    step(1, 3000, "R1");
    step(1, 9000, "R1");
    for (int i = 0; i < 8; i++) step(1, 0, "R1");

    in_valid = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule